// File: doc/BRIEF.md
# UART Channel Register Bank with Banked Baud Divisor

This block is the register file that a CPU sees for one serial channel of the 16550 kind. A 3-bit address, a write strobe and a read strobe select one of eight slots. The block holds the interrupt enable, line control, modem control and scratch registers, a 16-bit baud divisor, and a FIFO enable flag. Its outputs drive the framing settings, the break request, the modem control lines and the divisor.

Bit 7 of line control is the bank bit. When it is set, slots 0 and 1 reach the low and high divisor bytes instead of their normal registers. Slot 0 reads the receive data and writes the transmit data. Slot 2 reads the interrupt identification and writes the FIFO control. Line status and modem status are served read-only through the same decode.

Read data is combinational from the address and the current register state. Every register and strobe updates on the rising clock edge. The transmit load and FIFO control strobes carry no ready signal, so the block applies no back-pressure: each accepted write produces exactly one strobe cycle, and the receiving logic must take it in that cycle.

Top module: `ureg_bank`

## Requirements
- R1: While reset is low, and after it is released, every writable register reads 0. This covers the divisor (0x0000), all framing, modem and strobe outputs, and the FIFO enable flag.
- R2: With the bank bit clear, `rdata` returns the following. Slot 0 returns `rx_data`. Slot 3 returns the full line control byte. Slot 7 returns the scratch byte last written, and a scratch write changes no output other than the slot 7 read.
- R3: With line control bit 7 set, writes to slot 0 and slot 1 load divisor bits 7:0 and 15:8. Reads of those slots return the same bytes. `divisor` changes only after such a write.
- R4: Line control drives the outputs as follows: bits 1:0 `word_len`, bit 2 `stop2`, bit 3 `par_en`, bit 4 `par_even`, bit 5 `par_stick`, bit 6 `brk`. Bit 7 is the bank bit.
- R5: Interrupt enable keeps bits 3:0 of a write to slot 1 (bank clear) and drives them on `int_en`. Bits 7:4 always read 0.
- R6: Modem control (slot 4) maps bit 0 to `dtr`, bit 1 to `rts`, bit 2 to `out_gp` and bit 4 to `loop_en`. Bit 3 gates the interrupt, so that `irq` = bit 3 AND `int_pend`. Bits 7:5 read 0.
- R7: A read of slot 2 returns the following byte. Bit 0 is NOT `int_pend`. Bits 3:1 are `int_id`. Bits 5:4 are 0. Bits 7:6 are both 1 when the FIFO enable flag is set and 0 otherwise.
- R8: A write to slot 2 pulses `fcr_wr` for one cycle on the next edge and presents the written byte on `fcr_data`. Bit 0 of that byte loads the FIFO enable flag, which is output on `fifo_en`.
- R9: Slot 5 reads `lsr_in` and slot 6 reads `msr_in`. Writes to slots 5 and 6 change no register.
- R10: A read of slot 0 with the bank bit clear pulses `rx_pop` for exactly one cycle after the edge. No pulse follows when the bank bit is set.
- R11: A write of slot 0 with the bank bit clear pulses `tx_load` for one cycle and presents the byte on `tx_data`. No pulse follows when the bank bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register slot select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rx_data | input | 8 | Receive byte from the receiver |
| lsr_in | input | 8 | Line status view |
| msr_in | input | 8 | Modem status view |
| int_pend | input | 1 | Interrupt pending, active high |
| int_id | input | 3 | Identification code of the pending source |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Word length code |
| stop2 | output | 1 | Extra stop bit |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| par_stick | output | 1 | Stick parity |
| brk | output | 1 | Force line to spacing |
| int_en | output | 4 | Interrupt source enables |
| dtr | output | 1 | Data terminal ready output |
| rts | output | 1 | Request to send output |
| out_gp | output | 1 | General output bit |
| loop_en | output | 1 | Loopback select |
| irq | output | 1 | Gated interrupt |
| rx_pop | output | 1 | Receive buffer pop strobe |
| tx_load | output | 1 | Transmit load strobe |
| tx_data | output | 8 | Transmit byte |
| fcr_wr | output | 1 | FIFO control write strobe |
| fcr_data | output | 8 | FIFO control byte |
| fifo_en | output | 1 | FIFO enable flag |

## Verification
The stimulus goes after the slot 0 and slot 1 aliasing on both sides of a bank-bit change. A design that sampled the bank bit late would send a divisor byte to the transmitter, pop the receiver during a divisor read, or corrupt the interrupt enable register. Writes to the status slots are followed by reads of the registers they might have touched, which exposes any decode that reused a writable register. Random traffic compares every output on every cycle against a behavioural model, so a strobe that lasts two cycles or a reserved bit that reads 1 is caught where it first appears.

// File: rtl/ureg_pkg.sv
package ureg_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DIV_BYTES = 2;
  localparam int DIV_W = DW * DIV_BYTES;
  localparam int IEN_W = 4;
  localparam int MCR_W = 5;

  typedef enum logic [AW-1:0] {
    SLOT_DATA  = 3'd0,
    SLOT_IEN   = 3'd1,
    SLOT_IDENT = 3'd2,
    SLOT_LCTL  = 3'd3,
    SLOT_MCTL  = 3'd4,
    SLOT_LSTAT = 3'd5,
    SLOT_MSTAT = 3'd6,
    SLOT_SCR   = 3'd7
  } slot_e;

  typedef struct packed {
    logic       bank;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop2;
    logic [1:0] wlen;
  } lctl_t;
endpackage

// File: rtl/ureg_reg.sv
module ureg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/ureg_decode.sv
module ureg_decode
  import ureg_pkg::*;
(
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic                 bank,
  output logic                 we_ier,
  output logic                 we_lcr,
  output logic                 we_mcr,
  output logic                 we_scr,
  output logic                 we_fcr,
  output logic                 we_thr,
  output logic                 rd_rbr,
  output logic [DIV_BYTES-1:0] we_div
);
  always_comb begin
    we_ier = 1'b0;
    we_lcr = 1'b0;
    we_mcr = 1'b0;
    we_scr = 1'b0;
    we_fcr = 1'b0;
    we_thr = 1'b0;
    rd_rbr = 1'b0;
    we_div = '0;
    case (slot_e'(addr))
      SLOT_DATA: begin
        if (bank) we_div[0] = wr_en;
        else begin
          we_thr = wr_en;
          rd_rbr = rd_en;
        end
      end
      SLOT_IEN: begin
        if (bank) we_div[1] = wr_en;
        else      we_ier    = wr_en;
      end
      SLOT_IDENT: we_fcr = wr_en;
      SLOT_LCTL:  we_lcr = wr_en;
      SLOT_MCTL:  we_mcr = wr_en;
      SLOT_SCR:   we_scr = wr_en;
      default: ;
    endcase
  end
endmodule

// File: rtl/ureg_rdmux.sv
module ureg_rdmux
  import ureg_pkg::*;
(
  input  logic [AW-1:0]    addr,
  input  logic             bank,
  input  logic [DW-1:0]    rx_data,
  input  logic [IEN_W-1:0] ier,
  input  logic [DW-1:0]    iir,
  input  logic [DW-1:0]    lcr,
  input  logic [MCR_W-1:0] mcr,
  input  logic [DW-1:0]    lsr,
  input  logic [DW-1:0]    msr,
  input  logic [DW-1:0]    scr,
  input  logic [DIV_W-1:0] div,
  output logic [DW-1:0]    rdata
);
  always_comb begin
    case (slot_e'(addr))
      SLOT_DATA:  rdata = bank ? div[DW-1:0] : rx_data;
      SLOT_IEN:   rdata = bank ? div[2*DW-1:DW] : {{(DW-IEN_W){1'b0}}, ier};
      SLOT_IDENT: rdata = iir;
      SLOT_LCTL:  rdata = lcr;
      SLOT_MCTL:  rdata = {{(DW-MCR_W){1'b0}}, mcr};
      SLOT_LSTAT: rdata = lsr;
      SLOT_MSTAT: rdata = msr;
      default:    rdata = scr;
    endcase
  end
endmodule

// File: rtl/ureg_bank.sv
module ureg_bank
  import ureg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    rx_data,
  input  logic [DW-1:0]    lsr_in,
  input  logic [DW-1:0]    msr_in,
  input  logic             int_pend,
  input  logic [2:0]       int_id,
  output logic [DIV_W-1:0] divisor,
  output logic [1:0]       word_len,
  output logic             stop2,
  output logic             par_en,
  output logic             par_even,
  output logic             par_stick,
  output logic             brk,
  output logic [IEN_W-1:0] int_en,
  output logic             dtr,
  output logic             rts,
  output logic             out_gp,
  output logic             loop_en,
  output logic             irq,
  output logic             rx_pop,
  output logic             tx_load,
  output logic [DW-1:0]    tx_data,
  output logic             fcr_wr,
  output logic [DW-1:0]    fcr_data,
  output logic             fifo_en
);
  logic [DW-1:0]        lcr_q, scr_q;
  logic [MCR_W-1:0]     mcr_q;
  logic [IEN_W-1:0]     ier_q;
  logic [0:0]           fifo_q;
  logic                 we_ier, we_lcr, we_mcr, we_scr, we_fcr, we_thr, rd_rbr;
  logic [DIV_BYTES-1:0] we_div;
  logic [DW-1:0]        iir_view;
  lctl_t                lctl;

  assign lctl = lctl_t'(lcr_q);

  ureg_decode u_dec (
    .wr_en (wr_en), .rd_en(rd_en), .addr(addr), .bank(lctl.bank),
    .we_ier(we_ier), .we_lcr(we_lcr), .we_mcr(we_mcr), .we_scr(we_scr),
    .we_fcr(we_fcr), .we_thr(we_thr), .rd_rbr(rd_rbr), .we_div(we_div)
  );

  ureg_reg #(.W(DW))    u_lcr (.clk(clk), .rst_n(rst_n), .en(we_lcr), .d(wdata), .q(lcr_q));
  ureg_reg #(.W(DW))    u_scr (.clk(clk), .rst_n(rst_n), .en(we_scr), .d(wdata), .q(scr_q));
  ureg_reg #(.W(IEN_W)) u_ier (.clk(clk), .rst_n(rst_n), .en(we_ier), .d(wdata[IEN_W-1:0]), .q(ier_q));
  ureg_reg #(.W(MCR_W)) u_mcr (.clk(clk), .rst_n(rst_n), .en(we_mcr), .d(wdata[MCR_W-1:0]), .q(mcr_q));
  ureg_reg #(.W(1))     u_ffe (.clk(clk), .rst_n(rst_n), .en(we_fcr), .d(wdata[0]), .q(fifo_q));

  for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div
    ureg_reg #(.W(DW)) u_byte (
      .clk(clk), .rst_n(rst_n), .en(we_div[g]), .d(wdata), .q(divisor[g*DW +: DW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pop   <= 1'b0;
      tx_load  <= 1'b0;
      fcr_wr   <= 1'b0;
      tx_data  <= '0;
      fcr_data <= '0;
    end else begin
      rx_pop  <= rd_rbr;
      tx_load <= we_thr;
      fcr_wr  <= we_fcr;
      if (we_thr) tx_data  <= wdata;
      if (we_fcr) fcr_data <= wdata;
    end
  end

  assign iir_view = {{2{fifo_q[0]}}, 2'b00, int_id, ~int_pend};

  ureg_rdmux u_mux (
    .addr(addr), .bank(lctl.bank), .rx_data(rx_data), .ier(ier_q), .iir(iir_view),
    .lcr(lcr_q), .mcr(mcr_q), .lsr(lsr_in), .msr(msr_in), .scr(scr_q),
    .div(divisor), .rdata(rdata)
  );

  assign word_len  = lctl.wlen;
  assign stop2     = lctl.stop2;
  assign par_en    = lctl.par_en;
  assign par_even  = lctl.even;
  assign par_stick = lctl.stick;
  assign brk       = lctl.brk;
  assign int_en    = ier_q;
  assign dtr       = mcr_q[0];
  assign rts       = mcr_q[1];
  assign out_gp    = mcr_q[2];
  assign loop_en   = mcr_q[4];
  assign irq       = mcr_q[3] & int_pend;
  assign fifo_en   = fifo_q[0];
endmodule

// File: rtl/ureg_bank_chk.sv
module ureg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic        bank,
  input logic        int_pend,
  input logic [7:0]  rdata,
  input logic        irq,
  input logic        rx_pop,
  input logic        tx_load,
  input logic [15:0] divisor
);
  // R11
  tx_load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(wr_en && addr == 3'd0 && !bank));

  // R10
  rx_pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(rd_en && addr == 3'd0 && !bank));

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bank && addr <= 3'd1) |=> $stable(divisor));

  // R7
  iir_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 3'd2 |-> rdata[0] == !int_pend);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_pend);

  // R5
  ier_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd1 && !bank) |-> rdata[7:4] == 4'h0);
endmodule

bind ureg_bank ureg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .bank(lcr_q[7]), .int_pend(int_pend), .rdata(rdata), .irq(irq),
  .rx_pop(rx_pop), .tx_load(tx_load), .divisor(divisor)
);

// File: tb/sim_ureg_bank.sv
`timescale 1ns/1ps
module sim_ureg_bank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0, int_id = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, int_pend = 1'b0;
  logic [7:0] wdata = '0, rx_data = '0, lsr_in = '0, msr_in = '0;
  logic [7:0] rdata, tx_data, fcr_data;
  logic [15:0] divisor;
  logic [1:0] word_len;
  logic [3:0] int_en;
  logic stop2, par_en, par_even, par_stick, brk, dtr, rts, out_gp, loop_en, irq;
  logic rx_pop, tx_load, fcr_wr, fifo_en;

  always #10 clk = ~clk;

  ureg_bank u0 (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int m_lcr = 0, m_ier = 0, m_mcr = 0, m_scr = 0, m_dll = 0, m_dlm = 0, m_fifo = 0;
  int m_pop = 0, m_load = 0, m_txd = 0, m_fwr = 0, m_fd = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    int bank = (m_lcr >> 7) & 1;
    case (addr)
      3'd0: return bank ? m_dll : int'(rx_data);
      3'd1: return bank ? m_dlm : (m_ier & 'h0F);
      3'd2: return (m_fifo ? 'hC0 : 0) | (int'(int_id) << 1) | (int_pend ? 0 : 1);
      3'd3: return m_lcr;
      3'd4: return m_mcr & 'h1F;
      3'd5: return int'(lsr_in);
      3'd6: return int'(msr_in);
      default: return m_scr;
    endcase
  endfunction

  task automatic compare_all();
    chk("R2/R3/R5/R6/R7/R9 rdata", int'(rdata), exp_rdata());
    chk("R1/R3 divisor", int'(divisor), (m_dlm << 8) | m_dll);
    chk("R4 line fields", int'({brk, par_stick, par_even, par_en, stop2, word_len}), m_lcr & 'h7F);
    chk("R5 int_en", int'(int_en), m_ier & 'hF);
    chk("R6 modem pins", int'({loop_en, out_gp, rts, dtr}), ((m_mcr >> 4) & 1) * 8 + (m_mcr & 7));
    chk("R6 irq", int'(irq), ((m_mcr >> 3) & 1) & int'(int_pend));
    chk("R10 rx_pop", int'(rx_pop), m_pop);
    chk("R11 tx_load", int'(tx_load), m_load);
    chk("R11 tx_data", int'(tx_data), m_txd);
    chk("R8 fcr strobe/data", int'({fcr_wr, fcr_data}), (m_fwr << 8) | m_fd);
    chk("R8 fifo_en", int'(fifo_en), m_fifo);
  endtask

  task automatic model_edge();
    int bank = (m_lcr >> 7) & 1;
    int d = int'(wdata);
    m_pop  = (rd_en && addr == 0 && !bank) ? 1 : 0;
    m_load = (wr_en && addr == 0 && !bank) ? 1 : 0;
    m_fwr  = (wr_en && addr == 2) ? 1 : 0;
    if (m_load) m_txd = d;
    if (m_fwr) begin m_fd = d; m_fifo = d & 1; end
    if (wr_en) begin
      case (addr)
        3'd0: if (bank) m_dll = d;
        3'd1: if (bank) m_dlm = d; else m_ier = d & 'hF;
        3'd3: m_lcr = d;
        3'd4: m_mcr = d & 'h1F;
        3'd7: m_scr = d;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rx_data = 8'h3C; lsr_in = 8'h60; msr_in = 8'hB0;
    repeat (3) @(negedge clk);
    compare_all();                              // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();                              // R1 after release
    cyc(3'd7, 1, 0, 8'hA5);                     // R2 scratch
    cyc(3'd7, 0, 1, 8'h00);
    cyc(3'd1, 1, 0, 8'hFF);                     // R5 upper bits drop
    cyc(3'd3, 1, 0, 8'h7B);                     // R4 fields incl. break
    cyc(3'd4, 1, 0, 8'hFF);                     // R6
    int_pend = 1'b1; int_id = 3'd3;
    cyc(3'd2, 0, 1, 8'h00);                     // R7 pending
    cyc(3'd0, 0, 1, 8'h00);                     // R10 pop
    cyc(3'd0, 1, 0, 8'h55);                     // R11 load
    cyc(3'd3, 1, 0, 8'h83);                     // bank set
    cyc(3'd0, 1, 1, 8'h34);                     // R3 low byte, no pop/load
    cyc(3'd1, 1, 0, 8'h12);                     // R3 high byte, ier kept
    cyc(3'd0, 0, 1, 8'h00);
    cyc(3'd1, 0, 1, 8'h00);
    cyc(3'd3, 1, 0, 8'h03);                     // bank clear
    cyc(3'd1, 0, 1, 8'h00);                     // R5 ier survived
    cyc(3'd5, 1, 0, 8'hFF);                     // R9 ignored writes
    cyc(3'd6, 1, 0, 8'hFF);
    for (int s = 0; s < 8; s++) cyc(3'(s), 0, 1, 8'h00);
    cyc(3'd2, 1, 0, 8'h07);                     // R8 fifo on
    cyc(3'd2, 0, 0, 8'h00);
    int_pend = 1'b0;
    cyc(3'd2, 1, 0, 8'hC6);                     // R8 fifo off
    cyc(3'd4, 1, 0, 8'h08);                     // R6 irq gate only
    int_pend = 1'b1;
    cyc(3'd4, 0, 0, 8'h00);
    for (int i = 0; i < 2000; i++) begin
      rx_data = 8'($urandom); lsr_in = 8'($urandom); msr_in = 8'($urandom);
      int_pend = 1'($urandom); int_id = 3'($urandom);
      cyc(3'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule